// File: doc/BRIEF.md
# Sorted-Table Binary Search Engine

This block looks up an 8-bit unsigned key in a table of 32 ascending 8-bit entries. The table is held in an on-chip memory whose read address is captured in a register. It keeps a lower bound and an exclusive upper bound on the candidate indices, and probes the midpoint of that range. After each probe it drops the half that cannot hold the key. It stops when the probed entry equals the key or when the range is empty.

A host loads the table through a simple write port, or relies on the preset contents: entry i holds 7*i+3. It then raises an unsynchronised start level and waits for the done flag. The found flag and location report the result. They stay unchanged while start is held, and a new search begins only once start has gone low and then high again. A control FSM and a datapath are kept in separate modules.

Top module: `bsearch_top`

## Requirements
- R1: The table has 32 entries of 8 bits. Entry i is preset to 7*i+3. A write with wr_en high stores wr_data at wr_addr on the clock edge, and later searches use the new value.
- R2: A synchronous reset (rst high at a clock edge) returns the block to idle with done and found low, including during a search. start passes through two flip-flops before the controller sees it.
- R3: The read address of each probe is registered in the memory, and the entry is compared one cycle later. A probe therefore takes two cycles. A key at index 15 gives done 5 cycles after start is driven high, and a key at index 7 gives done after 7 cycles.
- R4: The comparison is unsigned. When the probed entry is greater than the key, the search continues in the indices below the midpoint. Otherwise it continues in the indices above the midpoint. The midpoint is (low+high)>>1 of the inclusive range.
- R5: On a match, loc equals the index of the matching entry, and found and done are both high.
- R6: A key that is absent ends with done high and found low. This holds for a key below entry 0 and for a key above entry 31. The bounds never wrap: the exclusive upper bound never exceeds 32.
- R7: While start stays high after done, done, found and loc hold. Raising start for a new search clears done before the new result is reported.
- R8: A search reports done no later than 18 clock cycles after start is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_async | input | 1 | Start request level, not synchronised |
| key | input | 8 | Value to look up |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 5 | Table write index |
| wr_data | input | 8 | Table write value |
| loc | output | 5 | Index of the matched entry |
| done | output | 1 | Search finished |
| found | output | 1 | Key present in table |

## Verification
On every cycle, the assertions check the following: the bounds stay within the table, every probe index lies inside the live range, and each narrowing step strictly shrinks the range. They also check that the compare state always follows an address issue, that found never rises without done, and that the result holds while start is held. The bench scenarios alone can show the actual index returned and the exact probe latencies. They also cover the unsigned handling of keys at 0 and 255, the effect of table writes, and the clearing of the result on reset or on a new start.

// File: rtl/bsearch_pkg.sv
package bsearch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CMP,
        ST_FIN
    } bs_state_e;

    typedef struct packed {
        logic ld_init;
        logic ld_mid;
        logic take_lower;
        logic take_upper;
        logic set_found;
    } bs_ctl_t;

endpackage

// File: rtl/bs_sync.sv
module bs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/bs_mem.sv
module bs_mem #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int PRESET_BASE = 3,
    parameter int PRESET_STEP = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] addr_d, addr_q;

    // Preset contents: an ascending arithmetic sequence
    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem_q[i] = DATA_W'(PRESET_BASE + PRESET_STEP * i);
    end

    always_comb begin
        addr_d = rd_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Address is registered; data for a new address is visible after the edge
    assign rd_data = mem_q[addr_q];
endmodule

// File: rtl/bs_datapath.sv
module bs_datapath
    import bsearch_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] key,
    input  logic [DATA_W-1:0] rd_data,
    input  bs_ctl_t           ctl,
    output logic [ADDR_W-1:0] probe_addr,
    output logic              empty,
    output logic              hit,
    output logic              mid_gt,
    output logic [ADDR_W-1:0] loc,
    output logic              found
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int BW    = ADDR_W + 1;   // room for the exclusive bound DEPTH

    typedef struct packed {
        logic [BW-1:0]     low;
        logic [BW-1:0]     hix;     // exclusive upper bound
        logic [ADDR_W-1:0] mid;
        logic [ADDR_W-1:0] loc;
        logic              found;
    } dp_t;

    dp_t r_d, r_q;
    logic [ADDR_W-1:0] mid_calc;

    always_comb begin
        empty    = (r_q.low >= r_q.hix);
        // inclusive-range midpoint; only meaningful when the range is non-empty
        mid_calc = empty ? r_q.low[ADDR_W-1:0]
                         : ADDR_W'((32'(r_q.low) + 32'(r_q.hix) - 32'd1) >> 1);
        hit      = (rd_data == key);
        mid_gt   = (rd_data > key);

        r_d = r_q;
        if (ctl.ld_init) begin
            r_d.low   = '0;
            r_d.hix   = BW'(DEPTH);
            r_d.found = 1'b0;
        end
        if (ctl.ld_mid)     r_d.mid   = mid_calc;
        if (ctl.take_lower) r_d.hix   = {1'b0, r_q.mid};
        if (ctl.take_upper) r_d.low   = {1'b0, r_q.mid} + BW'(1);
        if (ctl.set_found) begin
            r_d.found = 1'b1;
            r_d.loc   = r_q.mid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign probe_addr = mid_calc;
    assign loc        = r_q.loc;
    assign found      = r_q.found;

    assert_bound_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (r_q.hix <= BW'(DEPTH)) && (r_q.low <= BW'(DEPTH)));

    assert_probe_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.ld_mid |=> ({1'b0, r_q.mid} >= $past(r_q.low)) && ({1'b0, r_q.mid} < $past(r_q.hix)));

    assert_lower_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.take_lower |=> r_q.hix < $past(r_q.hix));

    assert_upper_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.take_upper |=> r_q.low > $past(r_q.low));
endmodule

// File: rtl/bs_ctrl.sv
module bs_ctrl
    import bsearch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_s,
    input  logic    empty,
    input  logic    hit,
    input  logic    mid_gt,
    output bs_ctl_t ctl,
    output logic    done
);
    typedef struct packed {
        bs_state_e state;
        logic      done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        ctl = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_s) begin
                    ctl.ld_init = 1'b1;
                    r_d.done    = 1'b0;
                    r_d.state   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (empty) begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_FIN;
                end else begin
                    ctl.ld_mid = 1'b1;     // address goes to the memory register
                    r_d.state  = ST_CMP;   // entry is readable one cycle later
                end
            end
            ST_CMP: begin
                if (hit) begin
                    ctl.set_found = 1'b1;
                    r_d.done      = 1'b1;
                    r_d.state     = ST_FIN;
                end else if (mid_gt) begin
                    ctl.take_lower = 1'b1;
                    r_d.state      = ST_ISSUE;
                end else begin
                    ctl.take_upper = 1'b1;
                    r_d.state      = ST_ISSUE;
                end
            end
            ST_FIN: begin
                if (!start_s) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_IDLE, done: 1'b0};
        else     r_q <= r_d;
    end

    assign done = r_q.done;

    assert_wait_before_compare_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_ISSUE && !empty) |=> (r_q.state == ST_CMP));

    assert_hold_while_start_R7: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_FIN && start_s) |=> (r_q.state == ST_FIN && r_q.done));
endmodule

// File: rtl/bsearch_top.sv
module bsearch_top
    import bsearch_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_async,
    input  logic [DATA_W-1:0] key,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] loc,
    output logic              done,
    output logic              found
);
    logic              start_s;
    logic [ADDR_W-1:0] probe_addr;
    logic [DATA_W-1:0] rd_data;
    logic              empty, hit, mid_gt;
    bs_ctl_t           ctl;

    bs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (start_async),
        .dout (start_s)
    );

    bs_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (probe_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    bs_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .key        (key),
        .rd_data    (rd_data),
        .ctl        (ctl),
        .probe_addr (probe_addr),
        .empty      (empty),
        .hit        (hit),
        .mid_gt     (mid_gt),
        .loc        (loc),
        .found      (found)
    );

    bs_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_s (start_s),
        .empty   (empty),
        .hit     (hit),
        .mid_gt  (mid_gt),
        .ctl     (ctl),
        .done    (done)
    );

    assert_found_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> $rose(done));
endmodule

// File: tb/sim_bsearch_top.sv
module sim_bsearch_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_async = 1'b0;
    logic [7:0] key = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] loc;
    logic       done, found;

    int n_chk  = 0;
    int n_fail = 0;
    int model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    bsearch_top u0 (
        .clk(clk), .rst(rst), .start_async(start_async), .key(key),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .loc(loc), .done(done), .found(found)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; start_async = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_entry(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(idx); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = val;
    endtask

    // Runs one search; exp_cyc < 0 checks only the R8 bound
    task automatic search(input int k, input bit exp_f, input int exp_loc,
                          input int exp_cyc, input string req);
        int cyc = 0;
        bit cleared = 0;
        @(negedge clk);
        key = 8'(k); start_async = 1'b1;
        while (cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (!done) cleared = 1;
            if (cleared && done) break;
        end
        chk(cleared, "R7", "done cleared by new start", int'(cleared), 1);
        chk(done, req, "done reached", int'(done), 1);
        chk(found == exp_f, req, $sformatf("found for key %0d", k), int'(found), int'(exp_f));
        if (exp_f) chk(int'(loc) == exp_loc, req, $sformatf("loc for key %0d", k), int'(loc), exp_loc);
        if (exp_cyc >= 0) chk(cyc == exp_cyc, "R3", $sformatf("latency key %0d", k), cyc, exp_cyc);
        chk(cyc <= 18, "R8", "latency bound", cyc, 18);
        start_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(!done && !found, "R2", "reset done|found", int'({done, found}), 0);
    endtask

    task automatic t_all_entries();
        for (int i = 0; i < 32; i++) search(model[i], 1'b1, i, -1, "R5");
    endtask

    task automatic t_latency();
        search(model[15], 1'b1, 15, 5, "R3");
        search(model[7], 1'b1, 7, 7, "R4");
    endtask

    task automatic t_absent();
        search(0, 1'b0, 0, -1, "R6");
        search(255, 1'b0, 0, -1, "R6");
        search(100, 1'b0, 0, -1, "R6");
    endtask

    task automatic t_unsigned_and_write();
        write_entry(31, 255);
        search(255, 1'b1, 31, -1, "R4");
        search(128, 1'b0, 0, -1, "R4");
        write_entry(0, 0);
        search(0, 1'b1, 0, -1, "R1");
        write_entry(0, 3);
        write_entry(31, 220);
        search(255, 1'b0, 0, -1, "R1");
    endtask

    task automatic t_hold();
        bit held = 1;
        @(negedge clk);
        key = 8'(model[20]); start_async = 1'b1;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            key = 8'(model[3]);   // key change while holding must not matter
            @(negedge clk);
            if (!(done && found && loc == 5'd20)) held = 0;
        end
        chk(held, "R7", "result held while start high", int'(held), 1);
        start_async = 1'b0;
        repeat (4) @(negedge clk);
        chk(done && found && loc == 5'd20, "R7", "result kept after release", int'(loc), 20);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        key = 8'(model[2]); start_async = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1; start_async = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(!done && !found, "R2", "reset mid-search", int'({done, found}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 7 * i + 3;
        t_reset_state();
        t_latency();
        t_all_entries();
        t_absent();
        t_unsigned_and_write();
        t_hold();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule